// File: doc/BRIEF.md
# Output Port Scheduler

This block is the routing engine of a crossbar switch. Up to `NPORTS` input ports raise a request that carries a destination address. The engine holds a forwarding table in a synchronous RAM, indexed by the requesting input together with the address. Each table entry is an output-port mask, so one packet may go to one output, several outputs or none. The engine makes one forwarding decision per fixed slot of `PERIOD` clocks. In each slot it picks one pending input in round-robin order and reads that input's table entry. If every output named in the entry is free, it sends the crossbar a one-cycle connect command that carries the input index and the mask. Those outputs stay busy until the crossbar reports that the end of the packet has passed through them.

During reconfiguration the processor raises `reconfig`. This stops new grants and opens the table to writes. An all-zero entry discards the packet: the input is connected to no output, so its buffered bytes drain away. A request whose outputs are not all free is skipped, and the input is tried again when the round-robin order reaches it.

Top module: `route_sched`

## Requirements
- R1: After reset no connect command is active and every output is free, so a request whose entry names all outputs is granted in the first slot it is evaluated.
- R2: Slots begin in the first cycle after reset is released and every `PERIOD` cycles after that. A connect command is asserted exactly two cycles after the start of the slot in which it was decided. Two commands are therefore always a multiple of `PERIOD` cycles apart.
- R3: The entry read for a request is at table index `{input, address}`: the input number in the upper `$clog2(NPORTS)` bits and the address in the lower `ADDR_W` bits. `conn_mask` carries that entry, and bit k of the mask stands for output k.
- R4: A request is granted only if every output in its mask is free. Otherwise it is skipped for that slot and stays pending.
- R5: At a slot start the candidate is the first input with `req_valid` high, searching upward, with wrap-around, from the input after the one evaluated last (input 0 after reset). Only an input that is requesting can be granted.
- R6: A granted output is busy from the cycle after the grant. It becomes free in the cycle after its bit is high on `rel_mask`.
- R7: An all-zero entry is always granted, with `conn_mask` equal to zero.
- R8: A table write (`tbl_we`) takes effect only while `reconfig` is high. At any other time it is ignored and the entry keeps its old contents.
- R9: No slot starts while `reconfig` is high. A slot already under way is not granted if `reconfig` is high in its decision cycle.
- R10: `conn_valid` is high for exactly one cycle per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | One request flag per input; held high until that input is granted |
| req_addr | input | NPORTS*ADDR_W | Destination address of each input, input i at bits [i*ADDR_W +: ADDR_W] |
| rel_mask | input | NPORTS | Outputs whose packet end has passed through them this cycle |
| reconfig | input | 1 | Blocks new grants and enables table writes |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(NPORTS)+ADDR_W | Table write index {input, address} |
| tbl_data | input | NPORTS | Output mask to store |
| conn_valid | output | 1 | One-cycle connect command to the crossbar |
| conn_in | output | $clog2(NPORTS) | Input index of the connection |
| conn_mask | output | NPORTS | Outputs of the connection |

## Verification
The hardest case to reach is a blocked request that waits while the round-robin pointer moves past it: a grant must follow as soon as a release frees its last busy output, and not before. The stimulus reaches this directly. It holds one output busy by withholding its release, presents a second input whose entry names that same output, and releases the output only after many skipped slots. Round-robin order is forced by raising three requests with disjoint masks in the same cycle, at a known pointer position. Randomized multicast traffic with random hold times then mixes blocking, discards and releases, while a behavioural model predicts every cycle.

// File: rtl/route_sched.sv
module route_sched #(
  parameter int NPORTS = 13,
  parameter int ADDR_W = 6,
  parameter int PERIOD = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORTS-1:0]         req_valid,
  input  logic [NPORTS*ADDR_W-1:0]  req_addr,
  input  logic [NPORTS-1:0]         rel_mask,
  input  logic                      reconfig,
  input  logic                      tbl_we,
  input  logic [$clog2(NPORTS)+ADDR_W-1:0] tbl_idx,
  input  logic [NPORTS-1:0]         tbl_data,
  output logic                      conn_valid,
  output logic [$clog2(NPORTS)-1:0] conn_in,
  output logic [NPORTS-1:0]         conn_mask
);
  localparam int IW    = $clog2(NPORTS);
  localparam int TW    = IW + ADDR_W;
  localparam int DEPTH = 1 << TW;
  localparam int CW    = $clog2(PERIOD);

  logic [NPORTS-1:0] mem [DEPTH];
  logic [NPORTS-1:0] rd_q, free;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     ptr, cand, pick;
  logic              active;

  always_comb begin
    pick = ptr;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (req_valid[(int'(ptr) + i) % NPORTS]) pick = IW'((int'(ptr) + i) % NPORTS);
  end

  wire [ADDR_W-1:0] pick_addr = req_addr[int'(pick)*ADDR_W +: ADDR_W];
  wire start  = (cnt == '0) && !reconfig && (|req_valid);
  wire decide = active && !reconfig && req_valid[cand];
  wire ok     = decide && ((rd_q & ~free) == '0);

  always_ff @(posedge clk) begin
    if (start) rd_q <= mem[{pick, pick_addr}];
    if (tbl_we && reconfig) mem[tbl_idx] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      ptr        <= '0;
      cand       <= '0;
      active     <= 1'b0;
      free       <= '1;
      conn_valid <= 1'b0;
      conn_in    <= '0;
      conn_mask  <= '0;
    end else begin
      cnt        <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
      active     <= start;
      if (start) cand <= pick;
      if (decide) ptr <= (cand == IW'(NPORTS - 1)) ? '0 : cand + 1'b1;
      free       <= (free | rel_mask) & ~(ok ? rd_q : '0);
      conn_valid <= ok;
      if (ok) begin
        conn_in   <= cand;
        conn_mask <= rd_q;
      end
    end
  end

  assert_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |-> cnt == CW'(2));
  assert_all_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |-> (($past(free) & conn_mask) == conn_mask));
  assert_requester_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |-> |($past(req_valid) & (NPORTS'(1) << conn_in)));
  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |-> ((free & conn_mask) == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |-> !$past(reconfig));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conn_valid |=> !conn_valid);
endmodule

// File: tb/tb_route_sched.sv
module tb_route_sched;
  localparam int NP = 13, AW = 6, PER = 6, IW = 4;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] req_valid = '0, rel_mask = '0, tbl_data = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic reconfig = 0, tbl_we = 0;
  logic [IW+AW-1:0] tbl_idx = '0;
  logic conn_valid;
  logic [IW-1:0] conn_in;
  logic [NP-1:0] conn_mask;

  route_sched #(.NPORTS(NP), .ADDR_W(AW), .PERIOD(PER)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [NP-1:0] req_v = '0, manual_rel = '0;
  logic [AW-1:0] addr_r [NP];
  int tmr [NP];
  bit auto_rel = 0, gen = 0, g_now = 0;
  int last_in = 0, prev_grant = -1;
  logic [NP-1:0] last_mask = '0;

  // behavioural model
  logic [NP-1:0] m_tbl [1024];
  int m_cnt = 0, m_ptr = 0, m_cand = 0;
  bit m_act = 0, m_cv = 0, ncv;
  int m_ci = 0;
  logic [NP-1:0] m_cm = '0, m_rd = '0, m_free = '1;
  string m_tag = "R1";

  function automatic logic [NP-1:0] tf(int i, int a);
    if (a == 0) return '0;
    if (a == 1) return '1;
    if (a < 40) return NP'(1) << ((i + a) % NP);
    return NP'(((a * 29 + i * 53) * 97) & 13'h1FFF) | (NP'(1) << (i % NP));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
    if (!rst_n) begin
      m_cnt = 0; m_ptr = 0; m_act = 0; m_cv = 0; m_free = '1; m_tag = "R1";
    end else begin
      ncv = 0;
      m_tag = m_cv ? "R10" : "R2";
      if (m_act) begin
        if (reconfig) m_tag = "R9";
        else if (req_valid[m_cand]) begin
          if ((m_rd & ~m_free) == '0) begin
            ncv = 1; m_ci = m_cand; m_cm = m_rd;
            m_tag = (m_rd == '0) ? "R7" : "R3";
          end else m_tag = "R4";
          m_ptr = (m_cand + 1) % NP;
        end
      end
      m_free = (m_free | rel_mask) & ~(ncv ? m_rd : '0);
      m_act = 0;
      if (m_cnt == 0 && !reconfig && req_valid != '0) begin
        for (int i = NP - 1; i >= 0; i--)
          if (req_valid[(m_ptr + i) % NP]) m_cand = (m_ptr + i) % NP;
        m_rd = m_tbl[m_cand * 64 + int'(req_addr[m_cand*AW +: AW])];
        m_act = 1;
      end
      if (tbl_we && reconfig) m_tbl[tbl_idx] = tbl_data;
      m_cv = ncv;
      m_cnt = (m_cnt + 1) % PER;
    end
  end

  task automatic check(string tag, string what, bit c, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(m_tag, "conn_valid", conn_valid === m_cv, 32'(conn_valid), 32'(m_cv));
    if (m_cv && conn_valid) begin
      check("R5", "conn_in", conn_in === IW'(m_ci), 32'(conn_in), 32'(m_ci));
      check(m_tag, "conn_mask", conn_mask === m_cm, 32'(conn_mask), 32'(m_cm));
    end
  endtask

  task automatic step();
    logic [NP-1:0] rel;
    @(negedge clk);
    compare();
    g_now = 0;
    tbl_we = 0;
    if (conn_valid) begin
      g_now = 1; last_in = int'(conn_in); last_mask = conn_mask;
      if (int'(conn_in) < NP) req_v[conn_in] = 0;
      if (auto_rel)
        for (int b = 0; b < NP; b++) if (conn_mask[b]) tmr[b] = 3 + int'($urandom % 25);
      // R2: grants are spaced by whole slots
      if (prev_grant >= 0)
        check("R2", "grant spacing", ((cyc - prev_grant) % PER) == 0, 32'(cyc - prev_grant), 32'(PER));
      prev_grant = cyc;
    end
    rel = manual_rel; manual_rel = '0;
    for (int b = 0; b < NP; b++)
      if (tmr[b] > 0) begin tmr[b]--; if (tmr[b] == 0) rel[b] = 1; end
    rel_mask = rel;
    if (gen)
      for (int p = 0; p < NP; p++)
        if (!req_v[p] && ($urandom % 8) == 0) begin req_v[p] = 1; addr_r[p] = AW'($urandom); end
    req_valid = req_v;
    for (int p = 0; p < NP; p++) req_addr[p*AW +: AW] = addr_r[p];
  endtask

  task automatic wait_conn(int port, int maxc, output bit seen, output logic [NP-1:0] m);
    seen = 0; m = '0;
    for (int k = 0; k < maxc && !seen; k++) begin
      step();
      if (g_now && last_in == port) begin seen = 1; m = last_mask; end
    end
  endtask

  task automatic request(int port, int a);
    req_v[port] = 1; addr_r[port] = AW'(a);
  endtask

  initial begin
    bit seen;
    logic [NP-1:0] m;
    int order [3];
    for (int b = 0; b < NP; b++) begin tmr[b] = 0; addr_r[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "conn_valid after reset", conn_valid === 1'b0, 32'(conn_valid), 0);

    reconfig = 1;
    for (int i = 0; i < 16; i++)
      for (int a = 0; a < 64; a++) begin
        step();
        tbl_we = 1; tbl_idx = 10'(i * 64 + a); tbl_data = tf(i, a);
      end
    step();
    reconfig = 0;

    // R1: everything free, broadcast entry granted
    request(3, 1);
    wait_conn(3, 40, seen, m);
    check("R1", "broadcast grant", seen && m == '1, 32'(m), 32'h1FFF);
    step();
    check("R10", "pulse ends", conn_valid === 1'b0, 32'(conn_valid), 0);
    manual_rel = '1;
    step();

    // R3 then R4/R6: a shared output blocks the second request until released
    request(2, 5);
    wait_conn(2, 40, seen, m);
    check("R3", "mask of {2,5}", seen && m == tf(2, 5), 32'(m), 32'(tf(2, 5)));
    request(4, 3);
    wait_conn(4, 40, seen, m);
    check("R4", "blocked request not granted", !seen, 32'(seen), 0);
    manual_rel = NP'(1) << 7;
    wait_conn(4, 40, seen, m);
    check("R6", "granted after release", seen && m == tf(4, 3), 32'(m), 32'(tf(4, 3)));
    manual_rel = NP'(1) << 7;
    step();

    // R7: discard entry
    request(6, 0);
    wait_conn(6, 40, seen, m);
    check("R7", "discard grant", seen && m == '0, 32'(m), 0);

    // R5: three simultaneous requests, pointer sits after input 6
    request(1, 10); request(5, 10); request(9, 10);
    for (int n = 0; n < 3; n++) begin
      seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
        step();
        if (g_now) begin seen = 1; order[n] = last_in; end
      end
    end
    check("R5", "first served", order[0] == 9, 32'(order[0]), 9);
    check("R5", "second served", order[1] == 1, 32'(order[1]), 1);
    check("R5", "third served", order[2] == 5, 32'(order[2]), 5);
    manual_rel = tf(1, 10) | tf(5, 10) | tf(9, 10);
    step();

    // R8: write outside reconfig is ignored, inside it is taken
    tbl_we = 1; tbl_idx = 10'(8 * 64 + 2); tbl_data = 13'h0003;
    step();
    request(8, 2);
    wait_conn(8, 40, seen, m);
    check("R8", "ignored write", seen && m == tf(8, 2), 32'(m), 32'(tf(8, 2)));
    manual_rel = m;
    step();
    reconfig = 1;
    step();
    tbl_we = 1; tbl_idx = 10'(8 * 64 + 2); tbl_data = 13'h0003;
    step();
    reconfig = 0;
    request(8, 2);
    wait_conn(8, 40, seen, m);
    check("R8", "accepted write", seen && m == 13'h0003, 32'(m), 3);
    manual_rel = m;
    step();

    // R9: reconfig holds off grants
    reconfig = 1;
    request(10, 7);
    wait_conn(10, 40, seen, m);
    check("R9", "no grant in reconfig", !seen, 32'(seen), 0);
    reconfig = 0;
    wait_conn(10, 40, seen, m);
    check("R9", "grant after reconfig", seen && m == tf(10, 7), 32'(m), 32'(tf(10, 7)));
    manual_rel = m;
    step();

    // random multicast traffic with random hold times
    auto_rel = 1; gen = 1;
    repeat (4000) step();
    gen = 0;
    for (int k = 0; k < 4000 && req_v != '0; k++) step();
    check("R4", "all requests eventually served", req_v == '0, 32'(req_v), 0);
    repeat (40) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule